// File: doc/BRIEF.md
# Complementary PWM Dead-Band Generator

This block turns a set of reference PWM waveforms into complementary high-side and low-side drive pairs for half-bridge power stages. Each pair changes state only after a programmable gap in which both switches are off. The gap is counted in cycles of the block clock and set by an 8-bit input. A value of zero gives plain complementary outputs with no gap. An auxiliary channel has no partner and passes its reference straight through.

A shutdown path protects the bridge. It has two sources: an external break input and a clock-fault indication. Either one forces every output low in the same cycle, with no clock edge needed. The break input also goes through a synchroniser. From there it clears the output-enable state and sets a sticky break flag. The outputs then stay low until an enable pulse arrives with no break cause active. The flag stays set until it is cleared by a clear pulse.

Top module: `cpwm_deadband`

## Requirements
- R1: After reset, every output and the break flag are 0, and the outputs stay 0 until the first enable pulse.
- R2: With a dead count of 0, each high-side output equals its reference delayed by one clock and the low-side output is its inverse, with no cycle where both are 0.
- R3: When a reference changes with a dead count D, both outputs of that pair are 0 for the D clocks after the edge that samples the change. The newly active side then turns on.
- R4: A reference pulse that lasts D clocks or fewer never turns on the side it would activate. A pulse of D+1 clocks turns it on for exactly one clock.
- R5: The auxiliary output follows its reference combinationally while the outputs are enabled. It has no complementary partner.
- R6: A high break input (active-high by default) forces all seven outputs to 0 in the same cycle, without waiting for a clock edge.
- R7: A break seen through the two-flop synchroniser clears the output enable and sets the break flag. The outputs remain 0 after the break input returns low, until an enable pulse is given.
- R8: A high clock-fault input forces all outputs to 0 at once. At the next clock edge it clears the output enable and sets the break flag.
- R9: The break flag stays set until a clear pulse arrives. A clear pulse while a break cause is still active leaves the flag set.
- R10: An enable pulse given while a synchronised break is active has no effect.
- R11: The two outputs of a pair are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; dead time is counted in these cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pwm | input | 3 | Reference PWM per complementary pair |
| ref_aux | input | 1 | Reference for the single-ended auxiliary channel |
| dead_cycles | input | 8 | Dead band length in clocks, 0 to 255 |
| out_en_set | input | 1 | Pulse that sets the output-enable state |
| brk_in | input | 1 | Asynchronous break input |
| clk_fail | input | 1 | Clock-fault indication, treated as a break cause |
| brk_flag_clr | input | 1 | Pulse that clears the sticky break flag |
| out_hi | output | 3 | High-side drive per pair |
| out_lo | output | 3 | Low-side drive per pair |
| out_aux | output | 1 | Auxiliary channel drive |
| brk_flag | output | 1 | Sticky break indication |

## Verification
The pairs are driven with a random reference pattern whose toggle rate is high enough to produce pulses both shorter and longer than the dead count. The dead count is also changed during the run, so a lane can be counting down from an older value while the input already holds a new one. Runs at a dead count of zero show whether the pairs stay gap-free. Runs at a non-zero count show whether the gap has the right length and starts on the right edge. Directed pulses of D and D+1 clocks show where a pulse stops being swallowed. Break and clock-fault sequences separate four things: the immediate combinational kill, the delayed loss of enable, an enable attempt made while a break is active, and a flag clear made while the cause is still present.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   // One half-bridge drive pair.
   typedef struct packed {
      logic hi;
      logic lo;
   } pair_t;
endpackage

// File: rtl/cpwm_sync.sv
module cpwm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/cpwm_dt_lane.sv
module cpwm_dt_lane #(
   parameter int DT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic [DT_W-1:0]  dead,
   output cpwm_pkg::pair_t  drv
);
   logic            ref_q;
   logic [DT_W-1:0] hold;
   logic            settled;

   // Every reference edge reloads the gap counter; a new edge during the
   // gap restarts it, which swallows pulses no longer than the gap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         hold  <= '0;
      end else if (ref_in != ref_q) begin
         ref_q <= ref_in;
         hold  <= dead;
      end else if (hold != '0) begin
         hold  <= hold - 1'b1;
      end
   end

   assign settled = (hold == '0);

   always_comb begin
      drv.hi = ref_q  & settled;
      drv.lo = ~ref_q & settled;
   end
endmodule

// File: rtl/cpwm_brk_ctrl.sv
module cpwm_brk_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic brk_sync,
   input  logic clk_fail,
   input  logic en_set,
   input  logic flag_clr,
   output logic out_en,
   output logic flag
);
   logic trip;

   assign trip = brk_sync | clk_fail;

   // A break cause always wins over a set or clear request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en <= 1'b0;
         flag   <= 1'b0;
      end else begin
         if (trip)        out_en <= 1'b0;
         else if (en_set) out_en <= 1'b1;
         if (trip)          flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
   parameter int NUM_PAIRS   = 3,
   parameter int DT_W        = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BRK_HIGH    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PAIRS-1:0] ref_pwm,
   input  logic                 ref_aux,
   input  logic [DT_W-1:0]      dead_cycles,
   input  logic                 out_en_set,
   input  logic                 brk_in,
   input  logic                 clk_fail,
   input  logic                 brk_flag_clr,
   output logic [NUM_PAIRS-1:0] out_hi,
   output logic [NUM_PAIRS-1:0] out_lo,
   output logic                 out_aux,
   output logic                 brk_flag
);
   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("NUM_PAIRS must be at least 1");
   end
   if (DT_W < 1) begin : g_bad_dtw
      $error("DT_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic brk_lvl;
   logic brk_sync;
   logic out_en;
   logic gate;

   if (BRK_HIGH) begin : g_brk_hi
      assign brk_lvl = brk_in;
   end else begin : g_brk_lo
      assign brk_lvl = ~brk_in;
   end

   cpwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (brk_lvl),
      .q     (brk_sync)
   );

   cpwm_brk_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .brk_sync (brk_sync),
      .clk_fail (clk_fail),
      .en_set   (out_en_set),
      .flag_clr (brk_flag_clr),
      .out_en   (out_en),
      .flag     (brk_flag)
   );

   // The raw break level acts on the outputs without any clock.
   assign gate = out_en & ~brk_lvl & ~clk_fail;

   for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_lane
      cpwm_pkg::pair_t drv;
      cpwm_dt_lane #(.DT_W(DT_W)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .ref_in (ref_pwm[i]),
         .dead   (dead_cycles),
         .drv    (drv)
      );
      assign out_hi[i] = drv.hi & gate;
      assign out_lo[i] = drv.lo & gate;
   end

   assign out_aux = ref_aux & gate;
endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk #(
   parameter int NUM_PAIRS = 3,
   parameter int DT_W      = 8,
   parameter bit BRK_HIGH  = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [DT_W-1:0]      dead_cycles,
   input logic                 brk_in,
   input logic                 clk_fail,
   input logic                 brk_flag_clr,
   input logic [NUM_PAIRS-1:0] out_hi,
   input logic [NUM_PAIRS-1:0] out_lo,
   input logic                 out_aux,
   input logic                 brk_flag,
   input logic                 out_en
);
   for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
      assert_pair_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !(out_hi[i] && out_lo[i]));

      assert_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (dead_cycles != '0 && $stable(dead_cycles) && $rose(out_hi[i]))
            |-> !$past(out_lo[i]));
   end

   assert_brk_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_in == BRK_HIGH) |-> (out_hi == '0 && out_lo == '0 && !out_aux));

   assert_en_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_flag) |-> !out_en);

   assert_fail_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_fail |=> brk_flag);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_flag && !brk_flag_clr) |=> brk_flag);
endmodule

bind cpwm_deadband cpwm_deadband_chk #(
   .NUM_PAIRS (NUM_PAIRS),
   .DT_W      (DT_W),
   .BRK_HIGH  (BRK_HIGH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dead_cycles  (dead_cycles),
   .brk_in       (brk_in),
   .clk_fail     (clk_fail),
   .brk_flag_clr (brk_flag_clr),
   .out_hi       (out_hi),
   .out_lo       (out_lo),
   .out_aux      (out_aux),
   .brk_flag     (brk_flag),
   .out_en       (out_en)
);

// File: tb/cpwm_deadband_bench.sv
module cpwm_deadband_bench;
   localparam int NP = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NP-1:0] ref_pwm = '0;
   logic          ref_aux = 1'b0;
   logic [7:0]    dead = 8'd0;
   logic          en_set = 1'b0, brk = 1'b0, cfail = 1'b0, fclr = 1'b0;
   logic [NP-1:0] hi, lo;
   logic          aux, flag;

   cpwm_deadband u_cpwm_deadband (
      .clk (clk), .rst_n (rst_n), .ref_pwm (ref_pwm), .ref_aux (ref_aux),
      .dead_cycles (dead), .out_en_set (en_set), .brk_in (brk),
      .clk_fail (cfail), .brk_flag_clr (fclr), .out_hi (hi), .out_lo (lo),
      .out_aux (aux), .brk_flag (flag)
   );

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // Independent reference model: time since last reference edge
   logic [NP-1:0] m_ref = '0;
   int m_age[NP];
   int m_need[NP];
   logic exp_gate = 1'b0;

   always @(posedge clk) begin
      for (int i = 0; i < NP; i++) begin
         if (!rst_n) begin
            m_ref[i] = 1'b0; m_age[i] = 0; m_need[i] = 0;
         end else if (ref_pwm[i] != m_ref[i]) begin
            m_ref[i] = ref_pwm[i]; m_age[i] = 0; m_need[i] = int'(dead);
         end else if (m_age[i] < 1000) begin
            m_age[i]++;
         end
      end
   end

   function automatic logic exp_hi(int i);
      return exp_gate && m_ref[i] && (m_age[i] >= m_need[i]);
   endfunction
   function automatic logic exp_lo(int i);
      return exp_gate && !m_ref[i] && (m_age[i] >= m_need[i]);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic all_off(string req);
      chk(req, {hi, lo, aux}, '0);
   endtask

   task automatic cycle_check(string tag = "");
      @(posedge clk);
      #2;
      for (int i = 0; i < NP; i++) begin
         string t;
         t = (tag != "") ? tag : ((m_need[i] == 0) ? "R2" : "R3");
         chk(t, hi[i], exp_hi(i));
         chk(t, lo[i], exp_lo(i));
         chk("R11", hi[i] & lo[i], 0);
      end
      chk((tag != "") ? tag : "R5", aux, exp_gate & ref_aux);
   endtask

   task automatic enable_pulse();
      en_set = 1'b1; exp_gate = 1'b1;
      cycle_check();
      en_set = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      bit seen;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      ref_aux = 1'b1;
      // R1: reset state, gated until enabled
      repeat (2) cycle_check("R1");
      chk("R1", flag, 0);
      all_off("R1");

      enable_pulse();
      // R2: dead count zero, directed toggles
      dead = 8'd0;
      for (int k = 0; k < 8; k++) begin
         ref_pwm = ref_pwm ^ NP'(k % 3 + 1);
         ref_aux = ~ref_aux;
         cycle_check("R2");
         cycle_check("R2");
      end

      // R4: pulses of D and D+1 clocks
      dead = 8'd4;
      ref_pwm = '0;
      repeat (6) cycle_check();
      ref_pwm[0] = 1'b1;
      for (int k = 0; k < 4; k++) begin
         cycle_check("R4");
         chk("R4", hi[0], 0);
      end
      ref_pwm[0] = 1'b0;
      repeat (6) cycle_check("R4");
      seen = 0;
      ref_pwm[0] = 1'b1;
      for (int k = 0; k < 5; k++) begin
         cycle_check("R4");
         if (hi[0]) seen = 1;
      end
      ref_pwm[0] = 1'b0;
      chk("R4", seen, 1);
      repeat (6) cycle_check("R4");

      // Random references, varying dead count
      for (int k = 0; k < 600; k++) begin
         if (k % 60 == 0) dead = 8'($urandom_range(6, 0));
         for (int i = 0; i < NP; i++)
            if ($urandom_range(3, 0) == 0) ref_pwm[i] = ~ref_pwm[i];
         ref_aux = 1'($urandom_range(1, 0));
         cycle_check();
      end

      // R6: break kills outputs immediately
      dead = 8'd2;
      ref_aux = 1'b1;
      repeat (4) cycle_check();
      brk = 1'b1;
      #1;
      all_off("R6");
      exp_gate = 1'b0;
      repeat (4) cycle_check("R6");
      chk("R7", flag, 1);
      // R10: enable attempt while break is active
      en_set = 1'b1;
      cycle_check("R10");
      en_set = 1'b0;
      brk = 1'b0;
      repeat (4) cycle_check("R10");
      // R7: still off after break removed
      repeat (3) cycle_check("R7");
      all_off("R7");
      enable_pulse();
      repeat (4) cycle_check("R7");
      // R9: flag sticky, then cleared
      chk("R9", flag, 1);
      fclr = 1'b1;
      cycle_check();
      fclr = 1'b0;
      chk("R9", flag, 0);

      // R8: clock fault
      cfail = 1'b1;
      #1;
      all_off("R8");
      exp_gate = 1'b0;
      cycle_check("R8");
      chk("R8", flag, 1);
      fclr = 1'b1;
      cycle_check("R9");
      fclr = 1'b0;
      chk("R9", flag, 1);
      cfail = 1'b0;
      repeat (2) cycle_check("R8");
      all_off("R8");
      fclr = 1'b1;
      cycle_check();
      fclr = 1'b0;
      chk("R9", flag, 0);
      enable_pulse();
      for (int k = 0; k < 40; k++) begin
         for (int i = 0; i < NP; i++)
            if ($urandom_range(2, 0) == 0) ref_pwm[i] = ~ref_pwm[i];
         cycle_check();
      end
      summary();
   end
endmodule